// File: doc/BRIEF.md
# Byte-Accessed 16-bit Timer with Compare

This block is a 16-bit up-counter with two 16-bit compare units, all reached over an 8-bit register bus. Each 16-bit value is moved in two byte accesses through one shared 8-bit holding register. Writes are made high byte first and then low byte. Reads are made low byte first and then high byte. Because of this, software never sees or writes a half-updated word, even while the counter is running.

A 3-bit clock-select field picks the count source:
- stopped;
- one of five taps of a free-running prescaler;
- rising or falling edges of an external input.

The external input is synchronised before its edges are detected. Each compare unit watches the counter on every timer tick. On a match it sets a sticky flag and, when enabled, toggles its waveform output. Writing the counter suppresses compare matches on the next tick, so loading a value equal to a compare register does not fire that unit at once.

Top module: `byte_timer16`

## Requirements
- R1: After reset the counter, both compare registers, the holding register, the control register, both flags and both waveform outputs are zero.
- R2: A write to an odd address below 6 only loads the holding register. A write to an even address below 6 loads {holding register, written byte} into the selected 16-bit register in one cycle. The selected registers are: 0 for the counter, 2 for compare unit A, 4 for compare unit B. The one holding register serves all three.
- R3: Control bits [2:0] select the count source. Code 0 stops the counter. Codes 1, 2, 3, 4 and 5 advance it once every 1, 8, 64, 256 and 1024 clocks respectively, taken from a free-running 10-bit prescaler. Each tick adds exactly one, wrapping at 16 bits.
- R4: Code 7 counts rising edges of `ext_clk_in` and code 6 counts falling edges. The input passes through two flip-flops before edge detection, and each qualifying edge adds exactly one.
- R5: A read of an even address below 6 returns the low byte of the selected register. In the same cycle it copies that register's high byte into the holding register. A read of an odd address below 6 returns the holding register.
- R6: On a timer tick where the counter value before the increment equals a unit's compare value, that unit's flag is set. Flag A is bit 0 of address 7 and of `flag_o`; flag B is bit 1.
- R7: When the unit's toggle enable is set, a match inverts that unit's bit of `wave_o`. The toggle enables are control bit 3 for unit A and bit 4 for unit B. With the enable clear, a match leaves the output unchanged.
- R8: Writing a one to a bit of address 7 clears that flag. Writing a zero has no effect, and a match in the same cycle wins over the clear.
- R9: A counter write blocks the compare match of both units on the next timer tick.
- R10: Address 6 reads back the control register, and address 7 reads {6'b0, flag B, flag A}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the prescaler input |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of `bus_rd` |
| ext_clk_in | input | 1 | External count input |
| wave_o | output | 2 | Compare waveform outputs, bit 0 for unit A |
| flag_o | output | 2 | Compare match flags, bit 0 for unit A |

## Verification
The counting function is driven in three ways, each showing a different failure:
- Each prescaler tap is run over a window of exactly four of its periods. A result of four counts shows that the tap is correct, whatever the prescaler phase.
- External pulses are counted in both edge modes. This separates double counting from wrong-edge counting.
- Counter and compare values are loaded so that unit B matches two ticks before unit A, with only A toggling. This places each flag and output change in an exact cycle.

A further run loads the counter equal to both compare values and must show no match. The byte-order tests read a low byte of one register and then a high byte of another. This proves that the high byte comes from the shared holding register and not from the addressed word.

// File: rtl/byte_timer16_pkg.sv
package byte_timer16_pkg;
  localparam int DATA_W  = 8;
  localparam int WORD_W  = 16;
  localparam int NUM_CMP = 2;
  localparam int PRE_W   = 10;

  typedef enum logic [2:0] {
    CS_STOP, CS_DIV1, CS_DIV8, CS_DIV64,
    CS_DIV256, CS_DIV1024, CS_EXT_FALL, CS_EXT_RISE
  } clk_sel_e;

  localparam logic [2:0] A_CNT_LO  = 3'd0;
  localparam logic [2:0] A_CTRL    = 3'd6;
  localparam logic [2:0] A_FLAGS   = 3'd7;

  // number of low prescaler bits that must be all ones for a tick
  function automatic int tap_shift(input logic [2:0] cs);
    case (cs)
      3'd1:    return 0;
      3'd2:    return 3;
      3'd3:    return 6;
      3'd4:    return 8;
      default: return 10;
    endcase
  endfunction

  function automatic logic [PRE_W-1:0] tap_mask(input logic [2:0] cs);
    return PRE_W'((1 << tap_shift(cs)) - 1);
  endfunction

  function automatic logic [WORD_W-1:0] join_bytes(input logic [DATA_W-1:0] hi,
                                                   input logic [DATA_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [WORD_W-1:0] step_count(input logic [WORD_W-1:0] v);
    return v + WORD_W'(1);
  endfunction
endpackage

// File: rtl/byte_timer16_tick.sv
module byte_timer16_tick
  import byte_timer16_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] clk_sel,
  input  logic       ext_in,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q;
  logic             sync1_q, sync2_q, last_q;
  logic             ext_rise, ext_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q   <= '0;
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      pre_q   <= pre_q + PRE_W'(1);
      sync1_q <= ext_in;
      sync2_q <= sync1_q;
      last_q  <= sync2_q;
    end
  end

  assign ext_rise = sync2_q & ~last_q;
  assign ext_fall = ~sync2_q & last_q;

  always_comb begin
    case (clk_sel)
      CS_STOP:     tick = 1'b0;
      CS_EXT_FALL: tick = ext_fall;
      CS_EXT_RISE: tick = ext_rise;
      default:     tick = (pre_q & tap_mask(clk_sel)) == tap_mask(clk_sel);
    endcase
  end

  AST_EXT_SINGLE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == CS_EXT_RISE && $past(clk_sel) == CS_EXT_RISE && tick) |=> !tick); // R4
endmodule

// File: rtl/byte_timer16_core.sv
module byte_timer16_core
  import byte_timer16_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             tick,
  input  logic                             cnt_wr,
  input  logic [NUM_CMP-1:0]               cmp_wr,
  input  logic [WORD_W-1:0]                wdata,
  input  logic [NUM_CMP-1:0]               tog_en,
  input  logic [NUM_CMP-1:0]               flag_clr,
  output logic [WORD_W-1:0]                cnt_q,
  output logic [NUM_CMP-1:0][WORD_W-1:0]   cmp_q,
  output logic [NUM_CMP-1:0]               flag_q,
  output logic [NUM_CMP-1:0]               wave_q,
  output logic [NUM_CMP-1:0]               match
);
  logic block_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      block_q <= 1'b0;
    end else begin
      if (cnt_wr)    cnt_q <= wdata;
      else if (tick) cnt_q <= step_count(cnt_q);
      if (cnt_wr)    block_q <= 1'b1;
      else if (tick) block_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_unit
    assign match[i] = tick & ~block_q & ~cnt_wr & (cnt_q == cmp_q[i]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmp_q[i]  <= '0;
        flag_q[i] <= 1'b0;
        wave_q[i] <= 1'b0;
      end else begin
        if (cmp_wr[i])        cmp_q[i]  <= wdata;
        if (match[i])         flag_q[i] <= 1'b1;
        else if (flag_clr[i]) flag_q[i] <= 1'b0;
        if (match[i] && tog_en[i]) wave_q[i] <= ~wave_q[i];
      end
    end

    AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      match[i] |=> flag_q[i]); // R6
    AST_WAVE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (match[i] && tog_en[i]) |=> wave_q[i] != $past(wave_q[i])); // R7
    AST_WAVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!match[i]) |=> $stable(wave_q[i])); // R7
    AST_BLOCKED_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (block_q && tick && !flag_q[i]) |=> !flag_q[i]); // R9
  end

  AST_INC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr) |=> cnt_q == $past(cnt_q) + 16'd1); // R3
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(cnt_q)); // R3
endmodule

// File: rtl/byte_timer16.sv
module byte_timer16
  import byte_timer16_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        ext_clk_in,
  output logic [1:0]  wave_o,
  output logic [1:0]  flag_o
);
  localparam int CTRL_W = 3 + NUM_CMP;

  logic [DATA_W-1:0]               temp_q;
  logic [CTRL_W-1:0]               ctrl_q;
  logic                            is_word, is_hi, is_lo, lo_wr, lo_rd;
  logic [1:0]                      word_idx;
  logic [WORD_W-1:0]               word_sel, wdata16;
  logic                            tick, cnt_wr;
  logic [NUM_CMP-1:0]              cmp_wr, flag_clr, match;
  logic [WORD_W-1:0]               cnt_q;
  logic [NUM_CMP-1:0][WORD_W-1:0]  cmp_q;
  logic [NUM_CMP-1:0]              flag_q, wave_q;

  assign is_word  = bus_addr < A_CTRL;
  assign is_hi    = is_word & bus_addr[0];
  assign is_lo    = is_word & ~bus_addr[0];
  assign word_idx = bus_addr[2:1];
  assign lo_wr    = bus_wr & is_lo;
  assign lo_rd    = bus_rd & ~bus_wr & is_lo;
  assign wdata16  = join_bytes(temp_q, bus_wdata);
  assign cnt_wr   = lo_wr & (word_idx == 2'd0);
  assign flag_clr = (bus_wr && bus_addr == A_FLAGS) ? bus_wdata[NUM_CMP-1:0] : '0;

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_dec
    assign cmp_wr[i] = lo_wr & (word_idx == 2'(i + 1));
  end

  always_comb begin
    case (word_idx)
      2'd0:    word_sel = cnt_q;
      2'd1:    word_sel = cmp_q[0];
      default: word_sel = cmp_q[1];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      temp_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (bus_wr && is_hi) temp_q <= bus_wdata;
      else if (lo_rd)      temp_q <= word_sel[WORD_W-1:DATA_W];
      if (bus_wr && bus_addr == A_CTRL) ctrl_q <= bus_wdata[CTRL_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (is_hi)                    bus_rdata = temp_q;
      else if (is_lo)               bus_rdata = word_sel[DATA_W-1:0];
      else if (bus_addr == A_CTRL)  bus_rdata = DATA_W'(ctrl_q);
      else                          bus_rdata = DATA_W'(flag_q);
    end
  end

  byte_timer16_tick u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_sel (ctrl_q[2:0]),
    .ext_in  (ext_clk_in),
    .tick    (tick)
  );

  byte_timer16_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .cnt_wr   (cnt_wr),
    .cmp_wr   (cmp_wr),
    .wdata    (wdata16),
    .tog_en   (ctrl_q[CTRL_W-1:3]),
    .flag_clr (flag_clr),
    .cnt_q    (cnt_q),
    .cmp_q    (cmp_q),
    .flag_q   (flag_q),
    .wave_q   (wave_q),
    .match    (match)
  );

  assign wave_o = wave_q;
  assign flag_o = flag_q;

  AST_HI_WRITE_TEMP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && is_hi) |=> temp_q == $past(bus_wdata)); // R2
  AST_LO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt_q == {$past(temp_q), $past(bus_wdata)}); // R2
  AST_LO_READ_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_rd && word_idx == 2'd0) |=> temp_q == $past(cnt_q[15:8])); // R5
  AST_MATCH_ONEHOT_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_q[0] != cmp_q[1]) |-> !(match[0] && match[1])); // R6
endmodule

// File: tb/byte_timer16_test.sv
module byte_timer16_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ext_clk_in = 1'b0;
  logic [1:0] wave_o, flag_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  byte_timer16 uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk_in(ext_clk_in),
    .wave_o(wave_o), .flag_o(flag_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr16(input logic [2:0] lo, input logic [15:0] v);
    reg_wr(lo + 3'd1, v[15:8]);
    reg_wr(lo, v[7:0]);
  endtask

  task automatic rd16(input logic [2:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    reg_rd(lo, l);
    reg_rd(lo + 3'd1, h);
    v = {h, l};
  endtask

  task automatic t_reset;
    logic [15:0] v;
    logic [7:0] b;
    rd16(3'd0, v); check("R1 counter", v, 0);
    rd16(3'd2, v); check("R1 compare A", v, 0);
    rd16(3'd4, v); check("R1 compare B", v, 0);
    reg_rd(3'd6, b); check("R1 control", b, 0);
    check("R1 flags", flag_o, 0);
    check("R1 waves", wave_o, 0);
  endtask

  task automatic t_map;
    logic [7:0] b;
    reg_wr(3'd6, 8'h18);
    reg_rd(3'd6, b); check("R10 control readback", b, 8'h18);
    reg_rd(3'd7, b); check("R10 flag register", b, 0);
    reg_wr(3'd6, 8'h00);
  endtask

  task automatic t_bytes;
    logic [15:0] v;
    logic [7:0] b;
    wr16(3'd2, 16'h5A21);
    wr16(3'd0, 16'h0307);
    rd16(3'd0, v); check("R2 counter write", v, 16'h0307);
    rd16(3'd2, v); check("R2 compare A write", v, 16'h5A21);
    reg_wr(3'd3, 8'hAB);
    rd16(3'd2, v); check("R2 high write alone leaves A", v, 16'h5A21);
    reg_wr(3'd3, 8'hAB);
    reg_wr(3'd4, 8'hCD);
    rd16(3'd4, v); check("R2 shared holding register into B", v, 16'hABCD);
    reg_rd(3'd2, b); check("R5 low byte of A", b, 8'h21);
    reg_rd(3'd1, b); check("R5 high read returns holding register", b, 8'h5A);
    reg_rd(3'd0, b); check("R5 low byte of counter", b, 8'h07);
    reg_rd(3'd1, b); check("R5 high byte of counter", b, 8'h03);
  endtask

  task automatic t_divider;
    logic [15:0] v;
    int divs[5] = '{1, 8, 64, 256, 1024};
    for (int k = 0; k < 5; k++) begin
      wr16(3'd0, 16'h0000);
      reg_wr(3'd6, 8'(k + 1));
      repeat (4 * divs[k] - 1) @(negedge clk);
      reg_wr(3'd6, 8'h00);
      rd16(3'd0, v);
      check($sformatf("R3 code %0d four periods", k + 1), v, 4);
    end
    repeat (20) @(negedge clk);
    rd16(3'd0, v); check("R3 stopped holds", v, 4);
  endtask

  task automatic pulses(input int n);
    for (int p = 0; p < n; p++) begin
      ext_clk_in = 1'b1; repeat (4) @(negedge clk);
      ext_clk_in = 1'b0; repeat (4) @(negedge clk);
    end
  endtask

  task automatic t_external;
    logic [15:0] v;
    wr16(3'd0, 16'h0000);
    reg_wr(3'd6, 8'h07);
    pulses(3);
    reg_wr(3'd6, 8'h00);
    rd16(3'd0, v); check("R4 rising edges", v, 3);
    wr16(3'd0, 16'h0000);
    reg_wr(3'd6, 8'h06);
    pulses(2);
    ext_clk_in = 1'b1; repeat (4) @(negedge clk);
    reg_wr(3'd6, 8'h00);
    rd16(3'd0, v); check("R4 falling edges", v, 2);
    ext_clk_in = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic t_compare;
    logic [7:0] b;
    reg_wr(3'd7, 8'h03);
    wr16(3'd0, 16'h0010);
    wr16(3'd2, 16'h0014);
    wr16(3'd4, 16'h0012);
    reg_wr(3'd6, 8'h09);      // divide-by-1, toggle A only
    repeat (2) @(negedge clk);
    check("R6 flag B before match", flag_o[1], 0);
    @(negedge clk);
    check("R6 flag B on match", flag_o[1], 1);
    check("R7 wave B unchanged without enable", wave_o[1], 0);
    @(negedge clk);
    check("R6 flag A before match", flag_o[0], 0);
    check("R7 wave A before match", wave_o[0], 0);
    @(negedge clk);
    check("R6 flag A on match", flag_o[0], 1);
    check("R7 wave A toggled", wave_o[0], 1);
    reg_wr(3'd6, 8'h08);
    reg_rd(3'd7, b); check("R10 flag register both set", b, 8'h03);
    reg_wr(3'd7, 8'h00);
    check("R8 writing zero keeps flags", flag_o, 2'b11);
    reg_wr(3'd7, 8'h01);
    check("R8 write one clears A only", flag_o, 2'b10);
    reg_wr(3'd7, 8'h02);
    check("R8 write one clears B", flag_o, 2'b00);
  endtask

  task automatic t_block;
    logic [15:0] v;
    wr16(3'd2, 16'h0040);
    wr16(3'd4, 16'h0040);
    wr16(3'd0, 16'h0040);
    reg_wr(3'd6, 8'h19);      // divide-by-1, both toggles on
    repeat (4) @(negedge clk);
    reg_wr(3'd6, 8'h00);
    check("R9 no flag after counter write", flag_o, 0);
    check("R9 waves unchanged", wave_o, 2'b01);
    rd16(3'd0, v); check("R9 counter still advanced", v, 16'h0045);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_bytes();
    t_divider();
    t_external();
    t_compare();
    t_block();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule